// File: doc/BRIEF.md
# Low-Power Multi-Channel Polling Sequencer

This block runs the polling loop of a low-power receiver. A list of up to 15 slots names the channels to be polled. Each slot holds a service number (0 to 4) and a channel number (0 to 2), which gives 5 services of 3 channels each. On a start command the sequencer goes through the eligible slots in list order. For each slot it shows the service and channel on its outputs and raises the receiver enable for a programmable listen window.

A preamble strobe from the demodulator extends the current window once, up to a programmable hold time. A telegram strobe ends polling, pulses an event output and leaves the service and channel of the hit on the outputs. A round that finds nothing is followed by a sleep request of programmable length, and then the list is polled again. When enabled, a one-cycle calibration request is inserted after every N-th sleep.

Configuration is written through a simple write port. Writes are taken only while the sequencer is idle. All pins are plain control and status signals with no flow control. The configuration port has no ready signal, because a write is always either taken or refused in the cycle it is presented.

Top module: `poll_seq`

## Requirements
- R1: After reset, rx_en, sleep_req, cal_req, event_irq and cfg_err are all low.
- R2: A start command in idle with at least one eligible slot raises rx_en from the next cycle, for listen-length cycles, on the first eligible slot. svc_o and chn_o show that slot.
- R3: Slots are polled in increasing list position. A slot is skipped if it is disabled, if its service is 5 or more, if its channel is 3 or more, or if its position is at or beyond the list length. While rx_en is high, svc_o is below 5 and chn_o is below 3.
- R4: After the last eligible slot, sleep_req is high for sleep-length cycles, and then polling restarts at the first eligible slot. rx_en and sleep_req are never high together.
- R5: pre_det in the base listen window reloads the window with hold-length cycles, counted from the next cycle. pre_det during an extension is ignored.
- R6: tel_found during a receive window drops rx_en in the next cycle and pulses event_irq for exactly one cycle. svc_o and chn_o keep the channel of the hit, and polling stops.
- R7: tel_found and pre_det are ignored outside receive windows: the sleep length is unchanged and no event is raised.
- R8: With a calibration interval N>0, a one-cycle cal_req follows every N-th sleep of a run, directly before the next listen window. N=0 disables calibration.
- R9: cmd_stop ends polling: in the next cycle rx_en, sleep_req and cal_req are low, and no event is raised.
- R10: A configuration write while polling is ignored and sets cfg_err. cfg_err is cleared by the next accepted start.
- R11: A start command is ignored when no slot is eligible, and also while polling is already running.
- R12: A listen, hold or sleep length of 0 acts as 1.
- R13: Writes in idle use this map. Addresses 0 to 14 are slot entries: bit 7 enable, bits [4:3] channel, bits [2:0] service. Address 16 is the list length (clamped to 15). Address 17 is the listen length, 18 the hold length, 19 the sleep length and 20 the calibration interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_start | input | 1 | Start polling (one-cycle strobe) |
| cmd_stop | input | 1 | Stop polling (one-cycle strobe) |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration address |
| cfg_wdata | input | 16 | Configuration write data |
| pre_det | input | 1 | Preamble detected strobe |
| tel_found | input | 1 | Valid telegram strobe |
| rx_en | output | 1 | Receiver enable |
| svc_o | output | 3 | Current or hit service |
| chn_o | output | 2 | Current or hit channel |
| sleep_req | output | 1 | Low-power sleep request |
| cal_req | output | 1 | Calibration request |
| event_irq | output | 1 | Telegram event pulse |
| cfg_err | output | 1 | Refused configuration write |

## Verification
The first pattern is a mixed list over three rounds. It holds a disabled slot, a slot with an out-of-range service, one with an out-of-range channel and one beyond the list length. This separates correct eligibility filtering and ordering from simple index stepping, and it checks that calibration is inserted only after the second sleep. The second pattern sends a preamble, then a second preamble inside the extension, then a telegram. This separates a single bounded extension from repeated reloads, and shows whether the hit channel is held. The third pattern uses an empty list and then all-zero lengths with stray starts. This separates refused starts from restarts, and shows that zero lengths act as one.

// File: rtl/poll_pkg.sv
package poll_pkg;
  localparam int NUM_SVC = 5;
  localparam int NUM_CHN = 3;
  localparam int SVC_W   = 3;
  localparam int CHN_W   = 2;
  localparam int EN_BIT  = 7;

  typedef struct packed {
    logic             en;
    logic [SVC_W-1:0] svc;
    logic [CHN_W-1:0] chn;
  } slot_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LISTEN, ST_HOLD, ST_SLEEP, ST_CAL
  } st_e;

  typedef enum logic [1:0] {
    TM_LISTEN, TM_HOLD, TM_SLEEP
  } tsel_e;
endpackage

// File: rtl/poll_cfg.sv
module poll_cfg
  import poll_pkg::*;
#(
  parameter int NSLOT = 15,
  parameter int TW    = 16,
  parameter int AW    = 5,
  parameter int LW    = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [AW-1:0]        addr,
  input  logic [TW-1:0]        wdata,
  input  logic                 locked,
  input  logic                 err_clr,
  output slot_t [NSLOT-1:0]    slots,
  output logic  [LW-1:0]       len,
  output logic  [TW-1:0]       listen_len,
  output logic  [TW-1:0]       hold_len,
  output logic  [TW-1:0]       sleep_len,
  output logic  [TW-1:0]       cal_every,
  output logic                 err
);
  localparam int REG_BASE = 1 << $clog2(NSLOT);
  localparam logic [AW-1:0] A_LEN    = AW'(REG_BASE);
  localparam logic [AW-1:0] A_LISTEN = AW'(REG_BASE + 1);
  localparam logic [AW-1:0] A_HOLD   = AW'(REG_BASE + 2);
  localparam logic [AW-1:0] A_SLEEP  = AW'(REG_BASE + 3);
  localparam logic [AW-1:0] A_CAL    = AW'(REG_BASE + 4);

  logic wr_ok;
  assign wr_ok = we && !locked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slots <= '0;
    end else if (wr_ok) begin
      for (int i = 0; i < NSLOT; i++) begin
        if (addr == AW'(i)) begin
          slots[i].en  <= wdata[EN_BIT];
          slots[i].svc <= wdata[SVC_W-1:0];
          slots[i].chn <= wdata[SVC_W+CHN_W-1:SVC_W];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len        <= '0;
      listen_len <= TW'(1);
      hold_len   <= TW'(1);
      sleep_len  <= TW'(1);
      cal_every  <= '0;
    end else if (wr_ok) begin
      case (addr)
        A_LEN:    len <= (wdata > TW'(NSLOT)) ? LW'(NSLOT) : wdata[LW-1:0];
        A_LISTEN: listen_len <= wdata;
        A_HOLD:   hold_len   <= wdata;
        A_SLEEP:  sleep_len  <= wdata;
        A_CAL:    cal_every  <= wdata;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)            err <= 1'b0;
    else if (we && locked) err <= 1'b1;
    else if (err_clr)      err <= 1'b0;
  end
endmodule

// File: rtl/poll_pick.sv
module poll_pick
  import poll_pkg::*;
#(
  parameter int NSLOT = 15,
  parameter int LW    = 4,
  parameter int IW    = 4
) (
  input  slot_t [NSLOT-1:0] slots,
  input  logic  [LW-1:0]    len,
  input  logic  [IW-1:0]    cur_idx,
  input  logic              from_start,
  output logic              ok,
  output logic  [IW-1:0]    idx
);
  logic [NSLOT-1:0] elig;

  for (genvar g = 0; g < NSLOT; g++) begin : g_elig
    assign elig[g] = slots[g].en
                  && (slots[g].svc < SVC_W'(NUM_SVC))
                  && (slots[g].chn < CHN_W'(NUM_CHN))
                  && (LW'(g) < len)
                  && (from_start || (IW'(g) > cur_idx));
  end

  always_comb begin
    ok  = 1'b0;
    idx = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (elig[i]) begin
        ok  = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/poll_timer.sv
module poll_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] val,
  output logic          done
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - TW'(1);
  end

  assign done = (cnt_q == TW'(1));
endmodule

// File: rtl/poll_ctrl.sv
module poll_ctrl
  import poll_pkg::*;
#(
  parameter int TW = 16,
  parameter int IW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_start,
  input  logic             cmd_stop,
  input  logic             pre_det,
  input  logic             tel_found,
  input  logic             pick_ok,
  input  logic [IW-1:0]    pick_idx,
  input  logic [SVC_W-1:0] pick_svc,
  input  logic [CHN_W-1:0] pick_chn,
  input  logic             tmr_done,
  input  logic [TW-1:0]    cal_every,
  output st_e              state,
  output logic [IW-1:0]    cur_idx,
  output logic             tmr_load,
  output tsel_e            tmr_sel,
  output logic [SVC_W-1:0] svc_o,
  output logic [CHN_W-1:0] chn_o,
  output logic             event_irq,
  output logic             start_ok
);
  st_e           nxt;
  logic          adv, ev;
  logic [TW-1:0] cyc_q, cyc_nxt;

  always_comb begin
    nxt      = state;
    tmr_load = 1'b0;
    tmr_sel  = TM_LISTEN;
    adv      = 1'b0;
    ev       = 1'b0;
    start_ok = 1'b0;
    cyc_nxt  = cyc_q;
    case (state)
      ST_IDLE: begin
        if (cmd_start && !cmd_stop && pick_ok) begin
          nxt      = ST_LISTEN;
          tmr_load = 1'b1;
          adv      = 1'b1;
          start_ok = 1'b1;
          cyc_nxt  = '0;
        end
      end
      ST_LISTEN, ST_HOLD: begin
        if (cmd_stop) begin
          nxt = ST_IDLE;
        end else if (tel_found) begin
          nxt = ST_IDLE;
          ev  = 1'b1;
        end else if (state == ST_LISTEN && pre_det) begin
          nxt      = ST_HOLD;
          tmr_load = 1'b1;
          tmr_sel  = TM_HOLD;
        end else if (tmr_done) begin
          tmr_load = 1'b1;
          if (pick_ok) begin
            nxt = ST_LISTEN;
            adv = 1'b1;
          end else begin
            nxt     = ST_SLEEP;
            tmr_sel = TM_SLEEP;
          end
        end
      end
      ST_SLEEP: begin
        if (cmd_stop) begin
          nxt = ST_IDLE;
        end else if (tmr_done) begin
          if (cal_every != '0 && cyc_q == cal_every - TW'(1)) begin
            nxt     = ST_CAL;
            cyc_nxt = '0;
          end else begin
            cyc_nxt = cyc_q + TW'(1);
            if (pick_ok) begin
              nxt      = ST_LISTEN;
              tmr_load = 1'b1;
              adv      = 1'b1;
            end else begin
              nxt = ST_IDLE;
            end
          end
        end
      end
      ST_CAL: begin
        if (cmd_stop || !pick_ok) begin
          nxt = ST_IDLE;
        end else begin
          nxt      = ST_LISTEN;
          tmr_load = 1'b1;
          adv      = 1'b1;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cur_idx   <= '0;
      svc_o     <= '0;
      chn_o     <= '0;
      event_irq <= 1'b0;
      cyc_q     <= '0;
    end else begin
      state     <= nxt;
      event_irq <= ev;
      cyc_q     <= cyc_nxt;
      if (adv) begin
        cur_idx <= pick_idx;
        svc_o   <= pick_svc;
        chn_o   <= pick_chn;
      end
    end
  end
endmodule

// File: rtl/poll_seq.sv
module poll_seq
  import poll_pkg::*;
#(
  parameter  int NSLOT = 15,
  parameter  int TW    = 16,
  localparam int AW    = $clog2(1 << $clog2(NSLOT)) + 1,
  localparam int LW    = $clog2(NSLOT + 1),
  localparam int IW    = $clog2(NSLOT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_start,
  input  logic             cmd_stop,
  input  logic             cfg_we,
  input  logic [AW-1:0]    cfg_addr,
  input  logic [TW-1:0]    cfg_wdata,
  input  logic             pre_det,
  input  logic             tel_found,
  output logic             rx_en,
  output logic [SVC_W-1:0] svc_o,
  output logic [CHN_W-1:0] chn_o,
  output logic             sleep_req,
  output logic             cal_req,
  output logic             event_irq,
  output logic             cfg_err
);
  slot_t [NSLOT-1:0] slots;
  logic  [LW-1:0]    len;
  logic  [TW-1:0]    listen_len, hold_len, sleep_len, cal_every;
  logic  [TW-1:0]    tmr_val;
  st_e               state;
  tsel_e             tmr_sel;
  logic  [IW-1:0]    cur_idx, pick_idx;
  logic              pick_ok, from_start, tmr_load, tmr_done, start_ok;

  assign from_start = (state == ST_IDLE) || (state == ST_SLEEP) || (state == ST_CAL);

  poll_cfg #(.NSLOT(NSLOT), .TW(TW), .AW(AW), .LW(LW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .locked(state != ST_IDLE), .err_clr(start_ok), .slots(slots), .len(len),
    .listen_len(listen_len), .hold_len(hold_len), .sleep_len(sleep_len),
    .cal_every(cal_every), .err(cfg_err)
  );

  poll_pick #(.NSLOT(NSLOT), .LW(LW), .IW(IW)) u_pick (
    .slots(slots), .len(len), .cur_idx(cur_idx), .from_start(from_start),
    .ok(pick_ok), .idx(pick_idx)
  );

  always_comb begin
    case (tmr_sel)
      TM_HOLD:  tmr_val = hold_len;
      TM_SLEEP: tmr_val = sleep_len;
      default:  tmr_val = listen_len;
    endcase
    if (tmr_val == '0) tmr_val = TW'(1);
  end

  poll_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .val(tmr_val), .done(tmr_done)
  );

  poll_ctrl #(.TW(TW), .IW(IW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
    .pre_det(pre_det), .tel_found(tel_found), .pick_ok(pick_ok),
    .pick_idx(pick_idx), .pick_svc(slots[pick_idx].svc),
    .pick_chn(slots[pick_idx].chn), .tmr_done(tmr_done), .cal_every(cal_every),
    .state(state), .cur_idx(cur_idx), .tmr_load(tmr_load), .tmr_sel(tmr_sel),
    .svc_o(svc_o), .chn_o(chn_o), .event_irq(event_irq), .start_ok(start_ok)
  );

  assign rx_en     = (state == ST_LISTEN) || (state == ST_HOLD);
  assign sleep_req = (state == ST_SLEEP);
  assign cal_req   = (state == ST_CAL);
endmodule

// File: rtl/poll_seq_chk.sv
module poll_seq_chk
  import poll_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_stop,
  input logic             cfg_we,
  input logic             rx_en,
  input logic [SVC_W-1:0] svc_o,
  input logic [CHN_W-1:0] chn_o,
  input logic             sleep_req,
  input logic             cal_req,
  input logic             event_irq,
  input logic             cfg_err
);
  // R4
  rx_sleep_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_en && sleep_req));

  // R6
  event_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    event_irq |=> !event_irq);

  // R6
  event_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    event_irq |-> (!rx_en && !sleep_req && !cal_req));

  // R10
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_err) |-> $past(cfg_we));

  // R8
  cal_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal_req |=> (!cal_req && rx_en));

  // R8
  cal_after_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cal_req) |-> $past(sleep_req));

  // R9
  stop_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stop |=> (!rx_en && !sleep_req && !cal_req && !event_irq));

  // R3
  valid_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en |-> (svc_o < SVC_W'(NUM_SVC) && chn_o < CHN_W'(NUM_CHN)));
endmodule

bind poll_seq poll_seq_chk u_chk (.*);

// File: tb/poll_seq_test.sv
module poll_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_start = 1'b0, cmd_stop = 1'b0, cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        pre_det = 1'b0, tel_found = 1'b0;
  logic        rx_en, sleep_req, cal_req, event_irq, cfg_err;
  logic [2:0]  svc_o;
  logic [1:0]  chn_o;

  always #4 clk = ~clk;

  poll_seq uut (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .pre_det(pre_det), .tel_found(tel_found), .rx_en(rx_en), .svc_o(svc_o),
    .chn_o(chn_o), .sleep_req(sleep_req), .cal_req(cal_req),
    .event_irq(event_irq), .cfg_err(cfg_err)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct packed { int kind; int svc; int chn; int len; int req; } seg_t;
  seg_t expq[$];

  task automatic check(bit ok, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, expv);
    end
  endtask

  // kind: 1 listen, 2 sleep, 3 calibration
  task automatic expect_seg(int kind, int svc, int chn, int len, int req);
    seg_t e;
    e.kind = kind; e.svc = svc; e.chn = chn; e.len = len; e.req = req;
    expq.push_back(e);
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg_write(int a, int d);
    cfg_we = 1'b1; cfg_addr = 5'(a); cfg_wdata = 16'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_start();
    cmd_start = 1'b1; @(negedge clk); cmd_start = 1'b0;
  endtask
  task automatic pulse_stop();
    cmd_stop = 1'b1; @(negedge clk); cmd_stop = 1'b0;
  endtask
  task automatic pulse_pre();
    pre_det = 1'b1; @(negedge clk); pre_det = 1'b0;
  endtask
  task automatic pulse_found();
    tel_found = 1'b1; @(negedge clk); tel_found = 1'b0;
  endtask

  // Monitor: cuts the output stream into segments and scores them
  int run_kind = 0, run_svc = 0, run_chn = 0, run_len = 0;
  always @(negedge clk) begin
    int k, s, c;
    seg_t e;
    if (rst_n) begin
      k = rx_en ? 1 : sleep_req ? 2 : cal_req ? 3 : 0;
      s = (k == 1) ? int'(svc_o) : 0;
      c = (k == 1) ? int'(chn_o) : 0;
      if (run_kind != 0 && (k != run_kind || s != run_svc || c != run_chn)) begin
        checks++;
        if (expq.size() == 0) begin
          errors++;
          $display("FAIL R2 unexpected segment actual kind=%0d svc=%0d chn=%0d len=%0d expected none",
                   run_kind, run_svc, run_chn, run_len);
        end else begin
          e = expq.pop_front();
          if (e.kind != run_kind || e.svc != run_svc || e.chn != run_chn || e.len != run_len) begin
            errors++;
            $display("FAIL R%0d segment actual kind=%0d svc=%0d chn=%0d len=%0d expected kind=%0d svc=%0d chn=%0d len=%0d",
                     e.req, run_kind, run_svc, run_chn, run_len, e.kind, e.svc, e.chn, e.len);
          end
        end
      end
      if (k != 0 && k == run_kind && s == run_svc && c == run_chn) run_len++;
      else begin
        run_kind = k; run_svc = s; run_chn = c; run_len = (k != 0) ? 1 : 0;
      end
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    check(!rx_en && !sleep_req && !cal_req && !event_irq && !cfg_err,
          "R1 outputs after reset", int'({rx_en, sleep_req, cal_req, event_irq, cfg_err}), 0);

    // R13 configuration in idle
    cfg_write(0, 'h88);   // svc0 chn1
    cfg_write(1, 'h01);   // disabled
    cfg_write(2, 'h94);   // svc4 chn2
    cfg_write(3, 'h85);   // svc5 invalid
    cfg_write(4, 'h9A);   // chn3 invalid
    cfg_write(5, 'h83);   // svc3 chn0
    cfg_write(6, 'h89);   // beyond length
    cfg_write(16, 6);
    cfg_write(17, 4);
    cfg_write(18, 5);
    cfg_write(19, 7);
    cfg_write(20, 2);
    check(!cfg_err, "R10 idle writes raise no error", int'(cfg_err), 0);

    // Pattern 1: three rounds, ordering R3, sleep R4, calibration R8
    for (int r = 0; r < 2; r++) begin
      expect_seg(1, 0, 1, 4, 2);
      expect_seg(1, 4, 2, 4, 3);
      expect_seg(1, 3, 0, 4, 3);
      expect_seg(2, 0, 0, 7, 4);  // R7 strays in first sleep
    end
    expect_seg(3, 0, 0, 1, 8);
    expect_seg(1, 0, 1, 4, 8);
    expect_seg(1, 4, 2, 2, 9);
    pulse_start();                          // now cycle 1
    tick(1);                                // cycle 2
    cfg_write(17, 9);                       // R10 write while active
    check(cfg_err, "R10 error after active write", int'(cfg_err), 1);
    tick(12);                               // cycle 15, in sleep
    pulse_found();                          // cycle 16
    check(!event_irq && sleep_req, "R7 found in sleep ignored", int'({event_irq, sleep_req}), 1);
    pulse_pre();                            // cycle 17
    tick(28);                               // cycle 45
    pulse_stop();                           // cycle 46
    check(!rx_en && !sleep_req && !cal_req && !event_irq, "R9 stop halts quietly",
          int'({rx_en, sleep_req, cal_req, event_irq}), 0);
    tick(3);
    check(!rx_en && !sleep_req, "R9 stays idle", int'({rx_en, sleep_req}), 0);

    // Pattern 2: extension R5 and telegram R6; listen still 4 (R10)
    expect_seg(1, 0, 1, 7, 5);
    expect_seg(1, 4, 2, 4, 10);
    expect_seg(1, 3, 0, 3, 6);
    pulse_start();                          // cycle 1
    check(!cfg_err, "R10 error cleared by start", int'(cfg_err), 0);
    tick(1);
    pulse_pre();                            // at cycle 2
    tick(1);
    pulse_pre();                            // at cycle 4, ignored
    tick(9);                                // cycle 14
    pulse_found();                          // cycle 15
    check(event_irq == 1'b1, "R6 event pulse", int'(event_irq), 1);
    check(!rx_en, "R6 receiver dropped", int'(rx_en), 0);
    check(svc_o == 3'd3 && chn_o == 2'd0, "R6 hit channel held", int'({svc_o, chn_o}), 'h0C);
    tick(1);
    check(!event_irq, "R6 event single cycle", int'(event_irq), 0);
    tick(5);
    check(!rx_en && !sleep_req && svc_o == 3'd3, "R6 polling stopped",
          int'({rx_en, sleep_req}), 0);

    // Pattern 3: empty list R11, zero lengths R12
    cfg_write(16, 0);
    pulse_start();
    check(!rx_en && !sleep_req, "R11 empty list start ignored", int'({rx_en, sleep_req}), 0);
    tick(3);
    check(!rx_en && !sleep_req, "R11 still idle", int'({rx_en, sleep_req}), 0);
    cfg_write(16, 1);
    cfg_write(17, 0);
    cfg_write(19, 0);
    cfg_write(20, 0);
    for (int r = 0; r < 2; r++) begin
      expect_seg(1, 0, 1, 1, 12);
      expect_seg(2, 0, 0, 1, 12);
    end
    expect_seg(1, 0, 1, 1, 11);
    pulse_start();                          // cycle 1
    tick(1);                                // cycle 2, sleep
    pulse_start();                          // R11 ignored while active
    tick(2);                                // cycle 5
    pulse_stop();
    tick(4);
    check(expq.size() == 0, "R2 all expected segments seen", expq.size(), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule